// File: doc/BRIEF.md
# Consecutive-Ones Run Detector

This block watches a single serial bit `x` that is sampled on every rising clock edge. It raises `y` once the most recent `RUN_LEN` samples of `x` have all been `1`. It does this without a shift register that holds the whole sample history. A three-state controller (idle, counting, detected) works together with a run counter that is only `ceil(log2(RUN_LEN))` bits wide. Flip-flop usage therefore grows with the logarithm of the run length, not linearly with it.

The idle state waits for the first `1`. The counting state adds one to the counter for each further `1`. A `0` in any state sends the controller back to idle and clears the counter. Once the run reaches `RUN_LEN`, the controller enters the detected state. It stays there while `x` stays `1`. `y` is decoded directly from the state register, so no output register sits in the path.

Top module: `ones_run_detector`

## Requirements
- R1: After the rising edge that samples the `RUN_LEN`-th consecutive `1` of `x`, `y` is 1. While fewer than `RUN_LEN` consecutive ones have been sampled since the last `0` or reset, `y` is 0.
- R2: A `0` sampled on `x` makes `y` 0 after that edge. Counting then starts again from zero, so `RUN_LEN` new ones are needed before `y` rises again.
- R3: Once `y` is 1, every further `1` sampled on `x` keeps `y` at 1, however long the run lasts.
- R4: With `rst` high at a rising edge (synchronous, active high), `y` is 0 after that edge. Any partial run is discarded.
- R5: With `RUN_LEN` = 1, a single sampled `1` raises `y` at that same edge, and a sampled `0` lowers it.
- R6: The run counter never exceeds `RUN_LEN-1`, and it holds 0 whenever the controller is idle.
- R7: `y` is a pure decode of the state register with no extra register stage. `y` changes in the clock cycle that follows the deciding edge, and never later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; `x` is sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset to idle |
| x | input | 1 | Serial bit under observation |
| y | output | 1 | High while the last `RUN_LEN` samples were all ones |

## Verification
Every result is due exactly one edge after the sample that decides it. The sample at rising edge k shows up on `y` during the low phase that follows edge k. The bench drives `x` on falling edges and reads `y` on the next falling edge, half a period after the rising edge that consumed the sample. No check waits an extra cycle, so a stray output register would make `y` one cycle late and fail the checks. The expected values come from a run-length count kept by the bench alongside the stimulus.

// File: rtl/ones_run_detector.sv
module ones_run_detector #(
  parameter int RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic x,
  output logic y
);

  localparam int CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_COUNT = 2'd1, S_HIT = 2'd2} st_t;

  st_t st, st_nx;
  logic [CW-1:0] cnt, cnt_nx;

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    case (st)
      S_IDLE: begin
        cnt_nx = '0;
        if (x) begin
          if (RUN_LEN == 1) st_nx = S_HIT;
          else begin
            st_nx  = S_COUNT;
            cnt_nx = CW'(1);
          end
        end
      end
      S_COUNT: begin
        if (!x) begin
          st_nx  = S_IDLE;
          cnt_nx = '0;
        end else if (cnt == LAST) begin
          st_nx  = S_HIT;
          cnt_nx = '0;
        end else begin
          cnt_nx = cnt + CW'(1);
        end
      end
      S_HIT: begin
        cnt_nx = '0;
        if (!x) st_nx = S_IDLE;
      end
      default: begin
        st_nx  = S_IDLE;
        cnt_nx = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_nx;
      cnt <= cnt_nx;
    end
  end

  assign y = (st == S_HIT);

  AST_ZERO_DROPS: assert property (@(posedge clk) disable iff (rst) !x |=> !y); // R2
  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (rst) (y && x) |=> y); // R3
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!y && cnt == '0)); // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst) cnt <= LAST); // R6
  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (rst) (st == S_IDLE) |-> (cnt == '0)); // R6
  AST_RISE_NEEDS_ONE: assert property (@(posedge clk) disable iff (rst) $rose(y) |-> $past(x)); // R1

endmodule

// File: tb/tb_ones_run_detector.sv
module tb_ones_run_detector;

  localparam int N = 4;
  localparam int NVEC = 32;
  localparam logic [0:NVEC-1] STIM = 32'b1111_1101_1101_1110_0101_1111_1101_1110;
  localparam logic [0:NVEC-1] EXPY = 32'b0001_1100_0000_0010_0000_0011_1100_0010;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x = 1'b0;
  logic y, y1;

  int applied = 0;
  int bad = 0;
  int run = 0;

  always #4 clk = ~clk;

  ones_run_detector #(.RUN_LEN(N)) dut (.clk(clk), .rst(rst), .x(x), .y(y));
  ones_run_detector #(.RUN_LEN(1)) dut1 (.clk(clk), .rst(rst), .x(x), .y(y1));

  task automatic check(input logic act, input logic exp, input string req);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: y=%0b expected %0b (cycle %0d)", req, act, exp, applied);
    end
  endtask

  task automatic step(input logic xv, input logic rv);
    x   = xv;
    rst = rv;
    @(posedge clk);
    if (rv) run = 0;
    else if (xv) run++;
    else run = 0;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    check(y, 1'b0, "R4 reset state");
    check(y1, 1'b0, "R4 reset state N=1");

    for (int k = 0; k < NVEC; k++) begin
      step(STIM[k], 1'b0);
      check(y, EXPY[k], "R1/R2 table");
      check(y, logic'(run >= N), "R1 model");
      check(y1, STIM[k], "R5 single-sample run");
    end

    step(1'b0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      step(1'b1, 1'b0);
      check(y, 1'b0, "R1 short run");
    end
    step(1'b1, 1'b0);
    check(y, 1'b1, "R7 same-cycle rise");
    for (int k = 0; k < 100; k++) begin
      step(1'b1, 1'b0);
      check(y, 1'b1, "R3 long run holds");
    end
    step(1'b0, 1'b0);
    check(y, 1'b0, "R2 zero drops");

    for (int k = 0; k < 3; k++) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    check(y, 1'b0, "R4 reset mid-run");
    for (int k = 0; k < 3; k++) begin
      step(1'b1, 1'b0);
      check(y, 1'b0, "R4 partial run discarded");
    end
    step(1'b1, 1'b0);
    check(y, 1'b1, "R4 fresh run completes");
    step(1'b1, 1'b1);
    check(y, 1'b0, "R4 reset from detected");
    check(y1, 1'b0, "R4 reset from detected N=1");

    step(1'b0, 1'b0);
    for (int k = 0; k < 2 * N; k++) begin
      step(1'b1, 1'b0);
      check(y, logic'(k >= N - 1), "R6 counter wraps into detect");
    end

    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

endmodule